// File: doc/BRIEF.md
# SDRAM Command Bus Bank-State Monitor

This block watches the command pins of a synchronous DRAM on every rising clock edge and decodes each cycle into a command code. It keeps track of whether each of the four banks holds an open row. It checks every command against two kinds of rule. The first kind depends on bank state: whether the command is legal given which banks are open. The second kind is a set of minimum spacings between commands, counted in clock cycles. The monitor sits next to a memory controller in simulation or on silicon and drives nothing onto the memory bus.

The timing minimums are module parameters, with defaults for a 7.5 ns clock. Each bank has its own down-counters. A counter is loaded when a command arrives and must reach zero before a dependent command may follow. The burst length is a parameter. It sets how long an auto-precharging read or write keeps its bank busy, and when the write-recovery window ends.

The first violation sets a sticky flag and captures a reason code and the bank involved. Later violations leave the capture unchanged until a synchronous clear.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_code` shows, one clock after each edge, the command sampled at that edge. With `cs_n` high the code is 0, whatever the other pins are. With `cs_n` low, {ras_n,cas_n,we_n} decodes as follows. 111 is NOP (1). 011 is ACT (2). 101 is READ (3), or READ with auto-precharge (4) when a10 is high. 100 is WRITE (5), or WRITE with auto-precharge (6) when a10 is high. 010 is PRE (7), or PRE-all (8) when a10 is high. 001 is REFRESH (9) when cke is high and SELF-REFRESH entry (12) when cke is low. 000 is MODE-SET (10). 110 is BURST-STOP (11).
- R2: `bank_active[b]` goes high on ACT to bank `ba`=b. It goes low on PRE to that bank. PRE-all (a10 high) clears every bank.
- R3: READ or WRITE with auto-precharge marks the bank idle at once. A new ACT to that bank must then wait for the burst plus tRP. For a read that is BURST_LEN+T_RP cycles. For a write it is BURST_LEN-1+T_WR+T_RP cycles. An earlier ACT is reported with code 8.
- R4: Bank-state violations are reported as follows. ACT to an open bank gives code 1. READ or WRITE to an idle bank gives code 2. BURST-STOP to an idle bank gives code 3. The bank reported is `ba`.
- R5: REFRESH or SELF-REFRESH entry while any bank is open gives code 4. MODE-SET while any bank is open gives code 5. Both report bank 0. After a refresh command every bank reads idle.
- R6: A READ or WRITE fewer than T_RCD cycles after ACT to the same bank gives code 6.
- R7: A PRE or PRE-all that reaches an open bank fewer than T_RAS cycles after its ACT gives code 7. For PRE-all, the lowest offending bank is reported.
- R8: An ACT fewer than T_RP cycles after a precharge of that bank gives code 8.
- R9: An ACT fewer than T_RRD cycles after any ACT gives code 9. An ACT fewer than T_RC cycles after an ACT to the same bank, or after a refresh command, gives code 10. When several checks fail in one cycle, the lowest code is reported.
- R10: A PRE reaching an open bank fewer than BURST_LEN-1+T_WR cycles after a WRITE to it gives code 11.
- R11: The first violation sets `err_flag` and latches `err_code` and `err_bank`. These outputs then hold through later violations. `clr_err` zeroes all three at the next edge, and it wins over a violation in the same cycle.
- R12: After reset, `cmd_code`, `bank_active`, `err_flag`, `err_code` and `err_bank` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Synchronous clear of the error capture |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| cke | input | 1 | Clock enable, separates refresh from self-refresh entry |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all option |
| cmd_code | output | 4 | Decoded command of the previous edge |
| bank_active | output | 4 | One bit per bank, high when a row is open |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Reason of the first violation |
| err_bank | output | 2 | Bank of the first violation |

## Verification
The assertions assume the following about the inputs. Every pin holds a defined 0 or 1 at each rising edge. Each edge carries exactly one command. `clr_err` is the only input that changes the error capture. The stimulus drives all pins on the falling edge from a single task, so it never produces an X or a glitch near the sampling edge. For every cycle it gives an explicit expected bank mask and an explicit expected violation, both computed by hand from the cycle counts in the requirements.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 9,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_err,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       cke,
  input  logic [1:0] ba,
  input  logic       a10,
  output logic [3:0] cmd_code,
  output logic [3:0] bank_active,
  output logic       err_flag,
  output logic [3:0] err_code,
  output logic [1:0] err_bank
);
  localparam int NB   = 4;
  localparam int MAXV = T_RC + T_RAS + BURST_LEN + T_WR + T_RP;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_WR  = CW'(BURST_LEN + T_WR - 2);
  localparam logic [CW-1:0] L_RDA = CW'(BURST_LEN + T_RP - 1);
  localparam logic [CW-1:0] L_WRA = CW'(BURST_LEN + T_WR + T_RP - 2);

  localparam logic [3:0] C_DESEL = 4'd0,  C_NOP  = 4'd1,  C_ACT  = 4'd2,  C_RD  = 4'd3,
                         C_RDA   = 4'd4,  C_WR   = 4'd5,  C_WRA  = 4'd6,  C_PRE = 4'd7,
                         C_PREA  = 4'd8,  C_REF  = 4'd9,  C_MRS  = 4'd10, C_BST = 4'd11,
                         C_SREF  = 4'd12;

  logic [3:0] cmd;
  logic [CW-1:0] rcd_c [NB];
  logic [CW-1:0] ras_c [NB];
  logic [CW-1:0] rp_c  [NB];
  logic [CW-1:0] rc_c  [NB];
  logic [CW-1:0] wr_c  [NB];
  logic [CW-1:0] rrd_c;
  logic [3:0] e_code;
  logic [1:0] e_bank;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  always_comb begin
    if (cs_n) cmd = C_DESEL;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = a10 ? C_RDA  : C_RD;
        3'b100:  cmd = a10 ? C_WRA  : C_WR;
        3'b010:  cmd = a10 ? C_PREA : C_PRE;
        3'b001:  cmd = cke ? C_REF  : C_SREF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_BST;
      endcase
    end
  end

  always_comb begin
    e_code = 4'd0;
    e_bank = ba;
    unique case (cmd)
      C_ACT:
        if (bank_active[ba])      e_code = 4'd1;
        else if (rp_c[ba] != '0)  e_code = 4'd8;
        else if (rrd_c != '0)     e_code = 4'd9;
        else if (rc_c[ba] != '0)  e_code = 4'd10;
      C_RD, C_RDA, C_WR, C_WRA:
        if (!bank_active[ba])     e_code = 4'd2;
        else if (rcd_c[ba] != '0) e_code = 4'd6;
      C_BST:
        if (!bank_active[ba])     e_code = 4'd3;
      C_PRE:
        if (bank_active[ba]) begin
          if (ras_c[ba] != '0)     e_code = 4'd7;
          else if (wr_c[ba] != '0) e_code = 4'd11;
        end
      C_PREA:
        for (int b = NB - 1; b >= 0; b--)
          if (bank_active[b] && (ras_c[b] != '0 || wr_c[b] != '0)) begin
            e_code = (ras_c[b] != '0) ? 4'd7 : 4'd11;
            e_bank = 2'(b);
          end
      C_REF, C_SREF: begin
        e_bank = 2'd0;
        if (|bank_active) e_code = 4'd4;
      end
      C_MRS: begin
        e_bank = 2'd0;
        if (|bank_active) e_code = 4'd5;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code    <= C_DESEL;
      bank_active <= '0;
      rrd_c       <= '0;
      for (int b = 0; b < NB; b++) begin
        rcd_c[b] <= '0; ras_c[b] <= '0; rp_c[b] <= '0; rc_c[b] <= '0; wr_c[b] <= '0;
      end
    end else begin
      cmd_code <= cmd;
      rrd_c    <= (cmd == C_ACT) ? L_RRD : dec(rrd_c);
      for (int b = 0; b < NB; b++) begin
        logic hit;
        hit = (ba == 2'(b));
        rcd_c[b] <= (cmd == C_ACT && hit) ? L_RCD : dec(rcd_c[b]);
        ras_c[b] <= (cmd == C_ACT && hit) ? L_RAS : dec(ras_c[b]);
        rc_c[b]  <= ((cmd == C_ACT && hit) || cmd == C_REF || cmd == C_SREF) ? L_RC : dec(rc_c[b]);
        wr_c[b]  <= ((cmd == C_WR || cmd == C_WRA) && hit) ? L_WR : dec(wr_c[b]);
        if ((cmd == C_PRE && hit) || cmd == C_PREA) rp_c[b] <= L_RP;
        else if (cmd == C_RDA && hit)               rp_c[b] <= L_RDA;
        else if (cmd == C_WRA && hit)               rp_c[b] <= L_WRA;
        else                                        rp_c[b] <= dec(rp_c[b]);
        if (cmd == C_ACT && hit) bank_active[b] <= 1'b1;
        else if (((cmd == C_PRE || cmd == C_RDA || cmd == C_WRA) && hit) ||
                 cmd == C_PREA || cmd == C_REF || cmd == C_SREF)
          bank_active[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0; err_code <= '0; err_bank <= '0;
    end else if (clr_err) begin
      err_flag <= 1'b0; err_code <= '0; err_bank <= '0;
    end else if (!err_flag && e_code != 4'd0) begin
      err_flag <= 1'b1; err_code <= e_code; err_bank <= e_bank;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_chk
    a_r2_act_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_active[g]) |-> $past(!cs_n && !ras_n && cas_n && we_n && ba == 2'(g)));
  end

  a_r3_autopre_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_RDA || cmd_code == C_WRA) |-> !bank_active[$past(ba)]);

  a_r5_refresh_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_REF || cmd_code == C_SREF) |-> bank_active == '0);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);

  a_r11_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> ($stable(err_code) && $stable(err_bank)));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (!err_flag && err_code == 4'd0));

  a_r11_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_code != 4'd0);
endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_err = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cmd_code, bank_active, err_code;
  logic       err_flag;
  logic [1:0] err_bank;

  always #2 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
    .cmd_code(cmd_code), .bank_active(bank_active), .err_flag(err_flag),
    .err_code(err_code), .err_bank(err_bank));

  typedef struct {
    logic [3:0] cmd; logic [3:0] act; logic flag; logic [3:0] code; logic [1:0] bank; string tag;
  } exp_t;
  exp_t q[$];

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic       x_flag = 1'b0;
  logic [3:0] x_code = '0;
  logic [1:0] x_bank = '0;

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic cyc(input logic [3:0] c, input logic [1:0] b, input logic [3:0] mask,
                     input logic [3:0] ec, input logic [1:0] eb, input bit clr, input string tag);
    exp_t e;
    @(negedge clk);
    cs_n = 1'b0; cke = 1'b1; a10 = 1'b0; ba = b; clr_err = clr;
    case (c)
      4'd0:  begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b001; end
      4'd1:  {ras_n, cas_n, we_n} = 3'b111;
      4'd2:  {ras_n, cas_n, we_n} = 3'b011;
      4'd3:  {ras_n, cas_n, we_n} = 3'b101;
      4'd4:  begin {ras_n, cas_n, we_n} = 3'b101; a10 = 1'b1; end
      4'd5:  {ras_n, cas_n, we_n} = 3'b100;
      4'd6:  begin {ras_n, cas_n, we_n} = 3'b100; a10 = 1'b1; end
      4'd7:  {ras_n, cas_n, we_n} = 3'b010;
      4'd8:  begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
      4'd9:  {ras_n, cas_n, we_n} = 3'b001;
      4'd10: {ras_n, cas_n, we_n} = 3'b000;
      4'd11: {ras_n, cas_n, we_n} = 3'b110;
      default: begin {ras_n, cas_n, we_n} = 3'b001; cke = 1'b0; end
    endcase
    if (clr) begin x_flag = 1'b0; x_code = '0; x_bank = '0; end
    else if (!x_flag && ec != 4'd0) begin x_flag = 1'b1; x_code = ec; x_bank = eb; end
    e.cmd = c; e.act = mask; e.flag = x_flag; e.code = x_code; e.bank = x_bank; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nops(input int n, input logic [3:0] mask);
    for (int i = 0; i < n; i++) cyc(4'd1, 2'd0, mask, 4'd0, 2'd0, 1'b0, "R1 nop");
  endtask

  task automatic clr(input logic [3:0] mask);
    cyc(4'd1, 2'd0, mask, 4'd0, 2'd0, 1'b1, "R11 clear");
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (cmd_code !== e.cmd || bank_active !== e.act || err_flag !== e.flag ||
          err_code !== e.code || err_bank !== e.bank) begin
        mismatched++;
        $display("FAIL %s: got cmd=%0d act=%b flag=%b code=%0d bank=%0d exp cmd=%0d act=%b flag=%b code=%0d bank=%0d",
                 e.tag, cmd_code, bank_active, err_flag, err_code, err_bank,
                 e.cmd, e.act, e.flag, e.code, e.bank);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got running exp finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (cmd_code !== 4'd0 || bank_active !== 4'd0 || err_flag !== 1'b0 ||
        err_code !== 4'd0 || err_bank !== 2'd0) begin
      mismatched++;
      $display("FAIL R12 reset: got cmd=%0d act=%b flag=%b code=%0d bank=%0d exp all zero",
               cmd_code, bank_active, err_flag, err_code, err_bank);
    end
    rst_n = 1'b1;

    cyc(4'd0, 2'd0, 4'h0, 4'd0, 2'd0, 1'b0, "R1 deselect ignores pins");
    cyc(4'd2, 2'd0, 4'h1, 4'd0, 2'd0, 1'b0, "R2 act bank0");
    nops(2, 4'h1);
    cyc(4'd3, 2'd0, 4'h1, 4'd0, 2'd0, 1'b0, "R6 read at tRCD");
    nops(2, 4'h1);
    cyc(4'd7, 2'd0, 4'h0, 4'd0, 2'd0, 1'b0, "R7 pre at tRAS");
    cyc(4'd2, 2'd0, 4'h1, 4'd8, 2'd0, 1'b0, "R8 act inside tRP");
    cyc(4'd2, 2'd1, 4'h3, 4'd9, 2'd1, 1'b0, "R11 first error held");
    clr(4'h3);
    cyc(4'd2, 2'd0, 4'h3, 4'd1, 2'd0, 1'b0, "R4 act to open bank");
    cyc(4'd3, 2'd2, 4'h3, 4'd2, 2'd2, 1'b1, "R11 clear wins");
    cyc(4'd5, 2'd2, 4'h3, 4'd2, 2'd2, 1'b0, "R4 write to idle bank");
    clr(4'h3);
    cyc(4'd11, 2'd3, 4'h3, 4'd3, 2'd3, 1'b0, "R4 stop to idle bank");
    clr(4'h3);
    cyc(4'd10, 2'd0, 4'h3, 4'd5, 2'd0, 1'b0, "R5 mode-set with open bank");
    clr(4'h3);
    cyc(4'd9, 2'd0, 4'h0, 4'd4, 2'd0, 1'b0, "R5 refresh with open bank");
    clr(4'h0);
    nops(10, 4'h0);

    cyc(4'd2, 2'd2, 4'h4, 4'd0, 2'd0, 1'b0, "R2 act bank2");
    nops(1, 4'h4);
    cyc(4'd3, 2'd2, 4'h4, 4'd6, 2'd2, 1'b0, "R6 read inside tRCD");
    clr(4'h4);
    cyc(4'd7, 2'd2, 4'h0, 4'd7, 2'd2, 1'b0, "R7 pre inside tRAS");
    clr(4'h0);
    nops(10, 4'h0);

    cyc(4'd2, 2'd3, 4'h8, 4'd0, 2'd0, 1'b0, "R2 act bank3");
    nops(2, 4'h8);
    cyc(4'd5, 2'd3, 4'h8, 4'd0, 2'd0, 1'b0, "R1 write");
    nops(2, 4'h8);
    cyc(4'd7, 2'd3, 4'h0, 4'd11, 2'd3, 1'b0, "R10 pre inside write recovery");
    clr(4'h0);
    nops(10, 4'h0);

    cyc(4'd2, 2'd1, 4'h2, 4'd0, 2'd0, 1'b0, "R2 act bank1");
    nops(2, 4'h2);
    cyc(4'd6, 2'd1, 4'h0, 4'd0, 2'd0, 1'b0, "R3 write auto-precharge idles bank");
    nops(6, 4'h0);
    cyc(4'd2, 2'd1, 4'h2, 4'd8, 2'd1, 1'b0, "R3 act before write auto-precharge done");
    clr(4'h2);
    nops(1, 4'h2);
    cyc(4'd4, 2'd1, 4'h0, 4'd0, 2'd0, 1'b0, "R3 read auto-precharge idles bank");
    nops(6, 4'h0);
    cyc(4'd2, 2'd1, 4'h2, 4'd0, 2'd0, 1'b0, "R3 act right after read auto-precharge");
    cyc(4'd2, 2'd0, 4'h3, 4'd9, 2'd0, 1'b0, "R9 act inside tRRD");
    clr(4'h3);
    nops(4, 4'h3);
    cyc(4'd8, 2'd0, 4'h0, 4'd0, 2'd0, 1'b0, "R2 precharge all");
    cyc(4'd9, 2'd0, 4'h0, 4'd0, 2'd0, 1'b0, "R5 refresh when idle");
    cyc(4'd12, 2'd0, 4'h0, 4'd0, 2'd0, 1'b0, "R1 self-refresh entry");
    nops(3, 4'h0);
    cyc(4'd2, 2'd2, 4'h4, 4'd10, 2'd2, 1'b0, "R9 act inside tRC after refresh");
    cyc(4'd0, 2'd0, 4'h4, 4'd0, 2'd0, 1'b0, "R1 deselect");

    repeat (3) @(negedge clk);
    report();
  end
endmodule